// File: doc/BRIEF.md
# Machine and Supervisor Control/Status Register File

This block holds the trap and status registers of a processor hart for machine and supervisor privilege. Any register is selected by a 12-bit register number. A combinational read port returns the addressed value in the same cycle. A write port captures one value per cycle, and that value is visible on the following cycle.

The supervisor status, interrupt-enable and interrupt-pending registers have no storage of their own. They are masked windows onto the machine registers:
- The status window passes a fixed set of supervisor fields.
- The interrupt windows pass only the bits set in the interrupt delegation register.

Some registers are changed on the way in or out:
- Exception-PC values are forced to instruction alignment.
- The trigger-select register reads back inverted, which signals that no triggers are present.
- The identity registers are constants.
- A free-running cycle counter and a retired-instruction counter can be overwritten. A write to either one takes priority over its increment in that cycle.

Top module: `csr_regfile`

## Requirements
- R1: After reset every stored register reads 0, except 0x7A0, which reads all ones, and 0xF11..0xF14, which read their ID parameters.
- R2: Addresses 0x302, 0x303, 0x305, 0x340, 0x342, 0x343, 0x102, 0x103, 0x105, 0x140, 0x142, 0x143 and 0x180 store the full written word and read it back unchanged.
- R3: Exception-PC registers 0x341 and 0x141 store the written value with its PC_ALIGN_BITS low bits cleared, and read with those bits zero.
- R4: Address 0x104 reads the machine enable register (0x304) ANDed with the delegation register (0x303). A write to 0x104 changes only the delegated bits of 0x304.
- R5: Address 0x144 uses the same masked aliasing onto the machine pending register (0x344).
- R6: Address 0x100 reads the machine status register (0x300) masked to bits 1, 5, 8, 18 and 19. A write to 0x100 changes only those bits of 0x300.
- R7: Address 0x7A0 reads back the bitwise inverse of the last value written to it.
- R8: The counter at 0xC00 rises by one on every clock. A write loads the written value instead of incrementing.
- R9: The counter at 0xC02 rises by one on each cycle with `retire` high. A write in the same cycle wins, and the counter holds the written value exactly.
- R10: Addresses 0xF11..0xF14 ignore writes.
- R11: Every address not listed in R1–R10 reads as zero and ignores writes.
- R12: The read port is combinational. A write becomes visible on the read port after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 12 | Register number to read |
| rd_data | output | XLEN | Read value, combinational |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Register number to write |
| wr_data | input | XLEN | Value to write |
| retire | input | 1 | One instruction retired this cycle |

## Verification
The bench builds the block with XLEN=32, PC_ALIGN_BITS=1 and four distinct ID constants. With these values the whole 12-bit register space can be swept, both read after reset and written with all ones. Using a single alignment bit exercises the finer-grained alignment case, and the distinct IDs make it possible to detect an address mix-up among the constants. All-ones and zero patterns written through the supervisor windows, under a sparse delegation mask, separate the masked bits from the preserved ones.

// File: rtl/csr_pkg.sv
package csr_pkg;

  localparam logic [11:0] ADDR_M_STATUS  = 12'h300;
  localparam logic [11:0] ADDR_M_EDELEG  = 12'h302;
  localparam logic [11:0] ADDR_M_IDELEG  = 12'h303;
  localparam logic [11:0] ADDR_M_IEN     = 12'h304;
  localparam logic [11:0] ADDR_M_TVEC    = 12'h305;
  localparam logic [11:0] ADDR_M_SCRATCH = 12'h340;
  localparam logic [11:0] ADDR_M_EPC     = 12'h341;
  localparam logic [11:0] ADDR_M_CAUSE   = 12'h342;
  localparam logic [11:0] ADDR_M_TVAL    = 12'h343;
  localparam logic [11:0] ADDR_M_IPEND   = 12'h344;
  localparam logic [11:0] ADDR_S_STATUS  = 12'h100;
  localparam logic [11:0] ADDR_S_EDELEG  = 12'h102;
  localparam logic [11:0] ADDR_S_IDELEG  = 12'h103;
  localparam logic [11:0] ADDR_S_IEN     = 12'h104;
  localparam logic [11:0] ADDR_S_TVEC    = 12'h105;
  localparam logic [11:0] ADDR_S_SCRATCH = 12'h140;
  localparam logic [11:0] ADDR_S_EPC     = 12'h141;
  localparam logic [11:0] ADDR_S_CAUSE   = 12'h142;
  localparam logic [11:0] ADDR_S_TVAL    = 12'h143;
  localparam logic [11:0] ADDR_S_IPEND   = 12'h144;
  localparam logic [11:0] ADDR_S_ATP     = 12'h180;
  localparam logic [11:0] ADDR_TRIG_SEL  = 12'h7A0;
  localparam logic [11:0] ADDR_CYCLES    = 12'hC00;
  localparam logic [11:0] ADDR_RETIRED   = 12'hC02;
  localparam logic [11:0] ADDR_ID_VENDOR = 12'hF11;
  localparam logic [11:0] ADDR_ID_ARCH   = 12'hF12;
  localparam logic [11:0] ADDR_ID_IMPL   = 12'hF13;
  localparam logic [11:0] ADDR_ID_HART   = 12'hF14;

  // Supervisor-visible status fields: bits 1, 5, 8, 18, 19.
  localparam logic [63:0] SUP_STATUS_MASK64 = 64'h0000_0000_000C_0122;

  // Registers with full-word storage and no side effects.
  localparam int NUM_PLAIN   = 14;
  localparam int IDX_IDELEG  = 1;
  localparam int IDX_TRIGSEL = 13;

  function automatic logic [11:0] plain_addr(input int idx);
    case (idx)
      0:       return ADDR_M_EDELEG;
      1:       return ADDR_M_IDELEG;
      2:       return ADDR_M_TVEC;
      3:       return ADDR_M_SCRATCH;
      4:       return ADDR_M_CAUSE;
      5:       return ADDR_M_TVAL;
      6:       return ADDR_S_EDELEG;
      7:       return ADDR_S_IDELEG;
      8:       return ADDR_S_TVEC;
      9:       return ADDR_S_SCRATCH;
      10:      return ADDR_S_CAUSE;
      11:      return ADDR_S_TVAL;
      12:      return ADDR_S_ATP;
      default: return ADDR_TRIG_SEL;
    endcase
  endfunction

endpackage

// File: rtl/csr_masked_reg.sv
module csr_masked_reg #(
  parameter int unsigned      W   = 32,
  parameter logic [W-1:0]     RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST;
    end else if (we) begin
      q <= (q & ~wmask) | (wdata & wmask);
    end
  end

endmodule

// File: rtl/csr_counters.sv
module csr_counters #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cyc_we,
  input  logic         ret_we,
  input  logic [W-1:0] wdata,
  input  logic         retire,
  output logic [W-1:0] cyc_q,
  output logic [W-1:0] ret_q
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
    end else if (cyc_we) begin
      cyc_q <= wdata;
    end else begin
      cyc_q <= cyc_q + ONE;
    end
  end

  // A write in the same cycle suppresses the retire increment.
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_q <= '0;
    end else if (ret_we) begin
      ret_q <= wdata;
    end else if (retire) begin
      ret_q <= ret_q + ONE;
    end
  end

  p_cycle_step_r8: assert property (@(posedge clk) disable iff (rst)
    !cyc_we |=> cyc_q == $past(cyc_q) + ONE);

  p_cycle_load_r8: assert property (@(posedge clk) disable iff (rst)
    cyc_we |=> cyc_q == $past(wdata));

  p_ret_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ret_we |=> ret_q == $past(wdata));

  p_ret_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ret_we && !retire) |=> $stable(ret_q));

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
  import csr_pkg::*;
#(
  parameter int unsigned     XLEN          = 32,
  parameter int unsigned     PC_ALIGN_BITS = 2,
  parameter logic [XLEN-1:0] VENDOR_ID     = '0,
  parameter logic [XLEN-1:0] ARCH_ID       = '0,
  parameter logic [XLEN-1:0] IMPL_ID       = '0,
  parameter logic [XLEN-1:0] HART_ID       = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [11:0]     rd_addr,
  output logic [XLEN-1:0] rd_data,
  input  logic            wr_en,
  input  logic [11:0]     wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            retire
);

  localparam logic [XLEN-1:0] ALL_ONES = '1;
  localparam logic [XLEN-1:0] SUP_MASK = SUP_STATUS_MASK64[XLEN-1:0];
  localparam logic [XLEN-1:0] PC_MASK  = ALL_ONES << PC_ALIGN_BITS;

  logic [XLEN-1:0] plain_q [NUM_PLAIN];
  logic [XLEN-1:0] status_q, ien_q, ipend_q, mepc_q, sepc_q;
  logic [XLEN-1:0] cyc_q, ret_q;
  logic [XLEN-1:0] ideleg;

  assign ideleg = plain_q[IDX_IDELEG];

  // Full-word registers.
  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    csr_masked_reg #(.W(XLEN), .RST('0)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en && (wr_addr == plain_addr(g))),
      .wmask (ALL_ONES),
      .wdata (wr_data),
      .q     (plain_q[g])
    );
  end

  // Status: full access from machine address, field-masked from supervisor address.
  logic            status_we;
  logic [XLEN-1:0] status_mask;
  assign status_we   = wr_en && (wr_addr == ADDR_M_STATUS || wr_addr == ADDR_S_STATUS);
  assign status_mask = (wr_addr == ADDR_S_STATUS) ? SUP_MASK : ALL_ONES;

  csr_masked_reg #(.W(XLEN), .RST('0)) u_status (
    .clk(clk), .rst(rst), .we(status_we), .wmask(status_mask),
    .wdata(wr_data), .q(status_q));

  // Interrupt enable: supervisor writes reach only delegated bits.
  logic            ien_we;
  logic [XLEN-1:0] ien_mask;
  assign ien_we   = wr_en && (wr_addr == ADDR_M_IEN || wr_addr == ADDR_S_IEN);
  assign ien_mask = (wr_addr == ADDR_S_IEN) ? ideleg : ALL_ONES;

  csr_masked_reg #(.W(XLEN), .RST('0)) u_ien (
    .clk(clk), .rst(rst), .we(ien_we), .wmask(ien_mask),
    .wdata(wr_data), .q(ien_q));

  // Interrupt pending: same aliasing scheme.
  logic            ipend_we;
  logic [XLEN-1:0] ipend_mask;
  assign ipend_we   = wr_en && (wr_addr == ADDR_M_IPEND || wr_addr == ADDR_S_IPEND);
  assign ipend_mask = (wr_addr == ADDR_S_IPEND) ? ideleg : ALL_ONES;

  csr_masked_reg #(.W(XLEN), .RST('0)) u_ipend (
    .clk(clk), .rst(rst), .we(ipend_we), .wmask(ipend_mask),
    .wdata(wr_data), .q(ipend_q));

  // Exception PCs: stored already aligned.
  csr_masked_reg #(.W(XLEN), .RST('0)) u_mepc (
    .clk(clk), .rst(rst), .we(wr_en && wr_addr == ADDR_M_EPC),
    .wmask(ALL_ONES), .wdata(wr_data & PC_MASK), .q(mepc_q));

  csr_masked_reg #(.W(XLEN), .RST('0)) u_sepc (
    .clk(clk), .rst(rst), .we(wr_en && wr_addr == ADDR_S_EPC),
    .wmask(ALL_ONES), .wdata(wr_data & PC_MASK), .q(sepc_q));

  csr_counters #(.W(XLEN)) u_counters (
    .clk    (clk),
    .rst    (rst),
    .cyc_we (wr_en && wr_addr == ADDR_CYCLES),
    .ret_we (wr_en && wr_addr == ADDR_RETIRED),
    .wdata  (wr_data),
    .retire (retire),
    .cyc_q  (cyc_q),
    .ret_q  (ret_q)
  );

  // Combinational read port.
  logic [XLEN-1:0] plain_rd;
  logic            plain_hit;

  always_comb begin
    plain_rd  = '0;
    plain_hit = 1'b0;
    for (int i = 0; i < NUM_PLAIN; i++) begin
      if (rd_addr == plain_addr(i)) begin
        plain_rd  = plain_q[i];
        plain_hit = 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_M_STATUS:  rd_data = status_q;
      ADDR_S_STATUS:  rd_data = status_q & SUP_MASK;
      ADDR_M_IEN:     rd_data = ien_q;
      ADDR_S_IEN:     rd_data = ien_q & ideleg;
      ADDR_M_IPEND:   rd_data = ipend_q;
      ADDR_S_IPEND:   rd_data = ipend_q & ideleg;
      ADDR_M_EPC:     rd_data = mepc_q & PC_MASK;
      ADDR_S_EPC:     rd_data = sepc_q & PC_MASK;
      ADDR_TRIG_SEL:  rd_data = ~plain_rd;
      ADDR_CYCLES:    rd_data = cyc_q;
      ADDR_RETIRED:   rd_data = ret_q;
      ADDR_ID_VENDOR: rd_data = VENDOR_ID;
      ADDR_ID_ARCH:   rd_data = ARCH_ID;
      ADDR_ID_IMPL:   rd_data = IMPL_ID;
      ADDR_ID_HART:   rd_data = HART_ID;
      default:        rd_data = plain_hit ? plain_rd : '0;
    endcase
  end

  p_epc_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_M_EPC || rd_addr == ADDR_S_EPC)
      |-> rd_data[PC_ALIGN_BITS-1:0] == '0);

  p_sien_view_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_S_IEN) |-> (rd_data & ~ideleg) == '0);

  p_sien_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_S_IEN)
      |=> ((ien_q ^ $past(ien_q)) & ~$past(ideleg)) == '0);

  p_sipend_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_S_IPEND)
      |=> ((ipend_q ^ $past(ipend_q)) & ~$past(ideleg)) == '0);

  p_sstatus_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_S_STATUS)
      |=> (status_q & ~SUP_MASK) == ($past(status_q) & ~SUP_MASK));

  p_trigsel_store_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_TRIG_SEL)
      |=> plain_q[IDX_TRIGSEL] == $past(wr_data));

endmodule

// File: tb/csr_regfile_test.sv
`timescale 1ns/1ps
module csr_regfile_test;

  localparam int          XLEN  = 32;
  localparam int          ALIGN = 1;
  localparam logic [31:0] VID   = 32'h0000_0A11;
  localparam logic [31:0] AID   = 32'h0000_0B22;
  localparam logic [31:0] IID   = 32'h0000_0C33;
  localparam logic [31:0] HID   = 32'h0000_0D44;
  localparam logic [31:0] SMASK = 32'h000C_0122;

  logic            clk = 0;
  logic            rst = 1;
  logic [11:0]     rd_addr = '0;
  logic [XLEN-1:0] rd_data;
  logic            wr_en = 0;
  logic [11:0]     wr_addr = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic            retire = 0;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  csr_regfile #(
    .XLEN(XLEN), .PC_ALIGN_BITS(ALIGN),
    .VENDOR_ID(VID), .ARCH_ID(AID), .IMPL_ID(IID), .HART_ID(HID)
  ) uut (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .retire(retire)
  );

  always #2.5 clk = ~clk;

  function automatic bit is_plain(input logic [11:0] a);
    case (a)
      12'h302, 12'h303, 12'h305, 12'h340, 12'h342, 12'h343,
      12'h102, 12'h103, 12'h105, 12'h140, 12'h142, 12'h143, 12'h180: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_impl(input logic [11:0] a);
    if (is_plain(a)) return 1;
    case (a)
      12'h300, 12'h304, 12'h341, 12'h344, 12'h100, 12'h104, 12'h141,
      12'h144, 12'h7A0, 12'hC00, 12'hC02,
      12'hF11, 12'hF12, 12'hF13, 12'hF14: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] reset_val(input logic [11:0] a);
    case (a)
      12'h7A0: return 32'hFFFF_FFFF;
      12'hF11: return VID;
      12'hF12: return AID;
      12'hF13: return IID;
      12'hF14: return HID;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [11:0] a,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%03h actual=%08h expected=%08h", req, a, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic sweep_reset(input string req);
    logic [31:0] v;
    for (int a = 0; a < 4096; a++) begin
      if (a != 12'hC00) begin
        rd(12'(a), v);
        check(req, 12'(a), v, reset_val(12'(a)));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1, R11: whole address space after reset
    sweep_reset("R1/R11 reset");

    // R11, R10: write all ones everywhere unimplemented and to ID registers
    for (int a = 0; a < 4096; a++) begin
      if (!is_impl(12'(a)) || (a >= 12'hF11 && a <= 12'hF14))
        wr(12'(a), 32'hFFFF_FFFF);
    end
    @(negedge clk);
    sweep_reset("R10/R11 ignored writes");

    // R2, R12: plain registers store full words
    for (int a = 0; a < 4096; a++)
      if (is_plain(12'(a))) wr(12'(a), 32'hA500_0000 ^ (a * 32'h0001_0001));
    for (int a = 0; a < 4096; a++)
      if (is_plain(12'(a))) begin
        rd(12'(a), v);
        check("R2 plain", 12'(a), v, 32'hA500_0000 ^ (a * 32'h0001_0001));
      end

    // R12: write visible after the next edge, read combinational
    @(negedge clk);
    wr_en = 1; wr_addr = 12'h340; wr_data = 32'h1234_5678;
    rd(12'h340, v);
    check("R12 before edge", 12'h340, v, 32'hA500_0000 ^ (32'h340 * 32'h0001_0001));
    @(negedge clk); wr_en = 0;
    rd(12'h340, v);
    check("R12 after edge", 12'h340, v, 32'h1234_5678);

    // R3: alignment of both exception PCs
    wr(12'h341, 32'hFFFF_FFFF); rd(12'h341, v);
    check("R3 mepc", 12'h341, v, 32'hFFFF_FFFF << ALIGN);
    wr(12'h141, 32'h8000_0003); rd(12'h141, v);
    check("R3 sepc", 12'h141, v, 32'h8000_0003 & (32'hFFFF_FFFF << ALIGN));

    // R4: supervisor enable window under a sparse delegation mask
    wr(12'h303, 32'h0000_0222);
    wr(12'h304, 32'hFFFF_FFFF);
    rd(12'h104, v); check("R4 view", 12'h104, v, 32'h0000_0222);
    wr(12'h104, 32'h0);
    rd(12'h304, v); check("R4 write keeps undelegated", 12'h304, v, 32'hFFFF_FDDD);
    wr(12'h104, 32'hFFFF_FFFF);
    rd(12'h304, v); check("R4 write sets delegated", 12'h304, v, 32'hFFFF_FFFF);
    wr(12'h304, 32'h0);
    wr(12'h104, 32'hFFFF_FFFF);
    rd(12'h304, v); check("R4 only delegated bits", 12'h304, v, 32'h0000_0222);

    // R5: supervisor pending window
    wr(12'h344, 32'h0000_F0F0);
    rd(12'h144, v); check("R5 view", 12'h144, v, 32'h0000_F0F0 & 32'h0000_0222);
    wr(12'h144, 32'hFFFF_FFFF);
    rd(12'h344, v); check("R5 write", 12'h344, v, 32'h0000_F2F2);
    wr(12'h144, 32'h0);
    rd(12'h344, v); check("R5 clear", 12'h344, v, 32'h0000_F0D0);

    // R6: supervisor status window
    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h100, v); check("R6 view", 12'h100, v, SMASK);
    wr(12'h100, 32'h0);
    rd(12'h300, v); check("R6 write keeps machine bits", 12'h300, v, ~SMASK);
    rd(12'h100, v); check("R6 view cleared", 12'h100, v, 32'h0);
    wr(12'h300, 32'h0);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h300, v); check("R6 only supervisor bits", 12'h300, v, SMASK);

    // R7: trigger select reads inverted
    wr(12'h7A0, 32'h1234_5678);
    rd(12'h7A0, v); check("R7 inverse", 12'h7A0, v, 32'hEDCB_A987);
    wr(12'h7A0, 32'h0);
    rd(12'h7A0, v); check("R7 zero", 12'h7A0, v, 32'hFFFF_FFFF);

    // R8: cycle counter
    @(negedge clk); rd(12'hC00, v);
    @(negedge clk); rd(12'hC00, v2);
    check("R8 step", 12'hC00, v2, v + 1);
    wr(12'hC00, 32'd100);
    rd(12'hC00, v); check("R8 load", 12'hC00, v, 32'd100);
    @(negedge clk); rd(12'hC00, v); check("R8 after load", 12'hC00, v, 32'd101);
    wr(12'hC00, 32'hFFFF_FFFF);
    @(negedge clk); rd(12'hC00, v); check("R8 wrap", 12'hC00, v, 32'd0);

    // R9: retired counter
    rd(12'hC02, v); check("R9 idle", 12'hC02, v, 32'd0);
    @(negedge clk); retire = 1;
    repeat (5) @(negedge clk);
    retire = 0;
    rd(12'hC02, v); check("R9 count", 12'hC02, v, 32'd5);
    retire = 1; wr_en = 1; wr_addr = 12'hC02; wr_data = 32'd50;
    @(negedge clk);
    wr_en = 0; retire = 0;
    rd(12'hC02, v); check("R9 write wins", 12'hC02, v, 32'd50);
    repeat (3) @(negedge clk);
    rd(12'hC02, v); check("R9 hold", 12'hC02, v, 32'd50);
    retire = 1; @(negedge clk); retire = 0;
    rd(12'hC02, v); check("R9 resume", 12'hC02, v, 32'd51);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule